// File: doc/BRIEF.md
# Power-Budgeted Variable-Period Test Clock Generator

This block drives a scan test clock whose period changes from one cycle to the next. Each cycle's energy is worked out ahead of time and arrives on a stream, one value per test clock cycle. Every value carries a tag that marks the cycle as a shift cycle or a capture cycle. The block scales the energy by a programmed fixed-point reciprocal of the peak-power limit and rounds the result up to whole reference-clock ticks. It then raises the result to the minimum delay that applies to the cycle's tag. The outcome is a cycle that never draws more than the power budget allows and is never shorter than the logic can tolerate.

The test clock is high for the first half of each period and low for the rest. The next energy value is accepted in the last tick of the current period, so one period follows the next with no gap. A running total of test time in ticks and a count of generated pulses are kept for software to read. A fixed-period mode applies one period to every cycle. That period comes from the largest cycle energy and gives a baseline for comparison. A start pulse clears the totals and begins a run. When the stream has nothing to offer at a period boundary, the clock stays low and a done flag rises.

Top module: `pwr_clk_gen`

## Requirements
- R1: In variable mode the period P of an accepted value E is the largest of three numbers: ceil(E * recip / 2^FRAC) ticks (FRAC = 8 by default), the minimum delay chosen by the tag (e_capture = 1 selects capt_min, e_capture = 0 selects shift_min), and 2.
- R2: In fixed mode every period equals the larger of ceil(emax * recip / 2^FRAC) and 2. The energy and the tag of each value have no effect.
- R3: A period begins on the clock edge after the edge that accepts a value. The test clock is high for floor(P/2) ticks and then low for the remaining P - floor(P/2) ticks.
- R4: e_ready is high in the single fetch cycle after start and during the last tick of each period, and is low at all other times. When a value is accepted in the last tick, the next period begins in the very next tick.
- R5: Each accepted value adds its P to total_time and adds 1 to cycle_count. Both values change on the accepting edge.
- R6: If e_valid is low at a point where e_ready is high, the run ends. done goes high, the test clock and e_ready stay low, and total_time and cycle_count hold until the next start, whatever e_valid does.
- R7: A start pulse clears total_time, cycle_count and done, and places the block in the fetch cycle. A value offered in the same cycle as start is not accepted.
- R8: sync_mode is sampled on the start pulse. Changes to sync_mode during a run do not affect any period of that run.
- R9: After reset the test clock, e_ready and done are low, and total_time and cycle_count are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one tick per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that clears totals and begins a run |
| sync_mode | input | 1 | 1 selects the fixed period (sampled at start) |
| recip | input | RW (16) | Reciprocal of the peak-power limit, FRAC fraction bits |
| shift_min | input | PW (24) | Minimum period in ticks for shift cycles |
| capt_min | input | PW (24) | Minimum period in ticks for capture cycles |
| emax | input | EW (16) | Largest cycle energy, used in fixed mode |
| e_valid | input | 1 | Energy value offered |
| e_data | input | EW (16) | Energy of the offered cycle |
| e_capture | input | 1 | Tag: 1 capture cycle, 0 shift cycle |
| e_ready | output | 1 | Block accepts the offered value on this edge |
| tck | output | 1 | Generated test clock (registered) |
| done | output | 1 | Stream ran empty; run finished |
| total_time | output | TW (40) | Sum of generated periods in ticks |
| cycle_count | output | CW (32) | Number of generated test clock pulses |

## Verification
A value is accepted on the rising edge where e_valid and e_ready are both high. From the next tick, tck is due high for floor(P/2) ticks and then low. e_ready is due in tick P-1, and total_time and cycle_count are already updated one tick after acceptance. The bench waits for the accepting edge and then samples tck and e_ready at the falling edge of each of the P ticks that follow. It checks the period as a whole shape and gives it one verdict. done and the final totals are read at the falling edge one tick after the last period ends. The reset state and the start-clear state are read at the first falling edge after reset and after the start edge.

// File: rtl/vclk_pkg.sv
package vclk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } vclk_state_e;

  // Round a fixed-point value up to an integer by shifting out sh fraction bits.
  function automatic logic [63:0] ceil_shift(input logic [63:0] v, input int unsigned sh);
    logic [63:0] bias;
    bias = (64'd1 << sh) - 64'd1;
    return (v + bias) >> sh;
  endfunction

  // Larger of two unsigned 64-bit values.
  function automatic logic [63:0] umax(input logic [63:0] a, input logic [63:0] b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/vclk_period_calc.sv
module vclk_period_calc #(
  parameter int EW   = 16,
  parameter int RW   = 16,
  parameter int FRAC = 8,
  parameter int PW   = 24
) (
  input  logic [EW-1:0] energy,
  input  logic [EW-1:0] emax,
  input  logic [RW-1:0] recip,
  input  logic          tag_capt,
  input  logic          fixed,
  input  logic [PW-1:0] shift_min,
  input  logic [PW-1:0] capt_min,
  output logic [PW-1:0] period
);
  import vclk_pkg::*;

  localparam logic [63:0] PER_CAP = (64'd1 << PW) - 64'd1;
  localparam logic [63:0] PER_FLOOR = 64'd2;

  logic [EW-1:0] e_sel;
  logic [63:0]   prod;
  logic [63:0]   scaled;
  logic [63:0]   tag_min;
  logic [63:0]   lower;
  logic [63:0]   chosen;

  always_comb begin
    e_sel   = fixed ? emax : energy;
    prod    = 64'(e_sel) * 64'(recip);
    scaled  = ceil_shift(prod, FRAC);
    tag_min = tag_capt ? 64'(capt_min) : 64'(shift_min);
    lower   = fixed ? PER_FLOOR : umax(tag_min, PER_FLOOR);
    chosen  = umax(scaled, lower);
    period  = (chosen > PER_CAP) ? PER_CAP[PW-1:0] : chosen[PW-1:0];
  end

endmodule

// File: rtl/vclk_phase_gen.sv
module vclk_phase_gen #(
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          load,
  input  logic [PW-1:0] load_per,
  input  logic          run,
  output logic          tck,
  output logic          last
);
  logic [PW-1:0] tick;
  logic [PW-1:0] per;
  logic [PW-1:0] hi_len;
  logic [PW-1:0] tick_nx;

  assign tick_nx = tick + 1'b1;
  assign last    = run && (tick == per - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick   <= '0;
      per    <= '0;
      hi_len <= '0;
      tck    <= 1'b0;
    end else if (clear) begin
      tick   <= '0;
      per    <= '0;
      hi_len <= '0;
      tck    <= 1'b0;
    end else if (load) begin
      tick   <= '0;
      per    <= load_per;
      hi_len <= load_per >> 1;
      tck    <= 1'b1;
    end else if (run) begin
      tick   <= tick_nx;
      tck    <= (tick_nx < hi_len);
    end else begin
      tck    <= 1'b0;
    end
  end

endmodule

// File: rtl/vclk_accum.sv
module vclk_accum #(
  parameter int PW = 24,
  parameter int TW = 40,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          add,
  input  logic [PW-1:0] amount,
  output logic [TW-1:0] total,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total <= '0;
      count <= '0;
    end else if (clear) begin
      total <= '0;
      count <= '0;
    end else if (add) begin
      total <= total + TW'(amount);
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/pwr_clk_gen.sv
module pwr_clk_gen #(
  parameter int EW   = 16,
  parameter int RW   = 16,
  parameter int FRAC = 8,
  parameter int PW   = 24,
  parameter int TW   = 40,
  parameter int CW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          sync_mode,
  input  logic [RW-1:0] recip,
  input  logic [PW-1:0] shift_min,
  input  logic [PW-1:0] capt_min,
  input  logic [EW-1:0] emax,
  input  logic          e_valid,
  input  logic [EW-1:0] e_data,
  input  logic          e_capture,
  output logic          e_ready,
  output logic          tck,
  output logic          done,
  output logic [TW-1:0] total_time,
  output logic [CW-1:0] cycle_count
);
  import vclk_pkg::*;

  vclk_state_e   state;
  logic          fixed_q;
  logic          run_state;
  logic          per_last;
  logic          ld_fire;
  logic          boundary;
  logic [PW-1:0] ld_per;

  assign run_state = (state == ST_RUN);
  assign boundary  = (state == ST_FETCH) || per_last;
  assign e_ready   = boundary;
  assign ld_fire   = boundary && e_valid && !start;
  assign done      = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      fixed_q <= 1'b0;
    end else if (start) begin
      state   <= ST_FETCH;
      fixed_q <= sync_mode;
    end else if (boundary) begin
      state   <= e_valid ? ST_RUN : ST_DONE;
    end
  end

  vclk_period_calc #(.EW(EW), .RW(RW), .FRAC(FRAC), .PW(PW)) u_calc (
    .energy    (e_data),
    .emax      (emax),
    .recip     (recip),
    .tag_capt  (e_capture),
    .fixed     (fixed_q),
    .shift_min (shift_min),
    .capt_min  (capt_min),
    .period    (ld_per)
  );

  vclk_phase_gen #(.PW(PW)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start),
    .load     (ld_fire),
    .load_per (ld_per),
    .run      (run_state),
    .tck      (tck),
    .last     (per_last)
  );

  vclk_accum #(.PW(PW), .TW(TW), .CW(CW)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (start),
    .add    (ld_fire),
    .amount (ld_per),
    .total  (total_time),
    .count  (cycle_count)
  );

endmodule

// File: rtl/pwr_clk_gen_chk.sv
module pwr_clk_gen_chk #(
  parameter int PW = 24,
  parameter int TW = 40,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          e_valid,
  input logic          e_ready,
  input logic          tck,
  input logic          done,
  input logic [TW-1:0] total_time,
  input logic [CW-1:0] cycle_count,
  input logic          ld_fire,
  input logic [PW-1:0] ld_per,
  input logic          per_last,
  input logic          run_state
);
  AST_PERIOD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fire |-> (ld_per >= PW'(2)));  // R1
  AST_LOAD_TCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fire |=> tck);  // R3
  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_state && per_last && e_valid && !start) |=> (tck && run_state));  // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fire |=> (cycle_count == $past(cycle_count) + 1'b1));  // R5
  AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fire |=> (total_time == $past(total_time) + TW'($past(ld_per))));  // R5
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!tck && !e_ready));  // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(total_time) && $stable(cycle_count) && done));  // R6
  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cycle_count == '0 && total_time == '0 && !done));  // R7
endmodule

bind pwr_clk_gen pwr_clk_gen_chk #(.PW(PW), .TW(TW), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .e_valid     (e_valid),
  .e_ready     (e_ready),
  .tck         (tck),
  .done        (done),
  .total_time  (total_time),
  .cycle_count (cycle_count),
  .ld_fire     (ld_fire),
  .ld_per      (ld_per),
  .per_last    (per_last),
  .run_state   (run_state)
);

// File: tb/pwr_clk_gen_test.sv
module pwr_clk_gen_test;
  localparam int CLK_NS = 10;
  localparam int MAXN = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        sync_mode = 1'b0;
  logic [15:0] recip = 16'h0100;
  logic [23:0] shift_min = '0;
  logic [23:0] capt_min = '0;
  logic [15:0] emax = '0;
  logic        e_valid = 1'b0;
  logic [15:0] e_data = '0;
  logic        e_capture = 1'b0;
  logic        e_ready;
  logic        tck;
  logic        done;
  logic [39:0] total_time;
  logic [31:0] cycle_count;

  int vectors = 0;
  int miscompares = 0;
  int e_arr [MAXN];
  bit t_arr [MAXN];

  always #(CLK_NS/2) clk = ~clk;

  pwr_clk_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .sync_mode(sync_mode),
    .recip(recip), .shift_min(shift_min), .capt_min(capt_min), .emax(emax),
    .e_valid(e_valid), .e_data(e_data), .e_capture(e_capture),
    .e_ready(e_ready), .tck(tck), .done(done),
    .total_time(total_time), .cycle_count(cycle_count)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Period model: division by the limit written as a ceiling quotient.
  function automatic int model_period(input int e, input bit capt, input bit fixed);
    longint num;
    int q;
    int lo;
    num = fixed ? longint'(emax) * longint'(recip) : longint'(e) * longint'(recip);
    q = int'(num / 256);
    if ((num % 256) != 0) q = q + 1;
    if (fixed) lo = 2;
    else begin
      lo = capt ? int'(capt_min) : int'(shift_min);
      if (lo < 2) lo = 2;
    end
    return (q > lo) ? q : lo;
  endfunction

  task automatic run_stream(input int n, input bit fixed, input bit flip, input string tag);
    longint tot = 0;
    int p;
    @(negedge clk);
    sync_mode = fixed;
    start = 1'b1;
    e_valid = 1'b1;
    e_data = 16'hFFFF;
    @(negedge clk);
    start = 1'b0;
    chk(cycle_count == 0 && total_time == 0 && !done && e_ready, "R7 start clears", longint'(cycle_count), 0);
    e_data = 16'(e_arr[0]);
    e_capture = t_arr[0];
    for (int j = 0; j < n; j++) begin
      bit ok = 1'b1;
      int bad_t = -1;
      @(posedge clk);
      p = model_period(e_arr[j], t_arr[j], fixed);
      tot = tot + p;
      for (int t = 0; t < p; t++) begin
        @(negedge clk);
        if (flip) sync_mode = ~sync_mode;
        if (tck != (t < p / 2) || e_ready != (t == p - 1)) begin
          if (ok) bad_t = t;
          ok = 1'b0;
        end
        if (t == p - 1) begin
          if (j + 1 < n) begin
            e_data = 16'(e_arr[j + 1]);
            e_capture = t_arr[j + 1];
          end else begin
            e_valid = 1'b0;
          end
        end
      end
      // R1 R2 R3 R4: shape of one period; actual is the first bad tick
      chk(ok, {tag, " R1 R2 R3 R4 R8 period shape"}, longint'(bad_t), longint'(p));
    end
    @(negedge clk);
    chk(done && !tck && !e_ready, "R6 done raised", longint'(done), 1);
    chk(total_time == 40'(tot), "R5 total_time", longint'(total_time), tot);
    chk(cycle_count == 32'(n), "R5 cycle_count", longint'(cycle_count), longint'(n));
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      e_valid = ~e_valid;
    end
    @(negedge clk);
    e_valid = 1'b0;
    chk(done && !tck && total_time == 40'(tot) && cycle_count == 32'(n),
        "R6 totals held after done", longint'(total_time), tot);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!tck && !e_ready && !done && total_time == 0 && cycle_count == 0, "R9 reset state", longint'(tck), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tck && !e_ready && !done, "R9 idle after reset", longint'(e_ready), 0);

    // Directed: unity reciprocal, tag-chosen minima, odd periods
    recip = 16'h0100; shift_min = 24'd3; capt_min = 24'd7;
    e_arr[0] = 0;  t_arr[0] = 0;   // 3
    e_arr[1] = 0;  t_arr[1] = 1;   // 7
    e_arr[2] = 5;  t_arr[2] = 0;   // 5
    e_arr[3] = 10; t_arr[3] = 1;   // 10
    e_arr[4] = 2;  t_arr[4] = 1;   // 7
    e_arr[5] = 9;  t_arr[5] = 0;   // 9
    run_stream(6, 1'b0, 1'b0, "dir-min");

    // Directed: fractional rounding up and the two-tick floor
    recip = 16'h0080; shift_min = 24'd0; capt_min = 24'd0;
    e_arr[0] = 5; t_arr[0] = 0;    // 3
    e_arr[1] = 7; t_arr[1] = 1;    // 4
    e_arr[2] = 1; t_arr[2] = 0;    // 2
    e_arr[3] = 0; t_arr[3] = 1;    // 2
    e_arr[4] = 3; t_arr[4] = 0;    // 2
    run_stream(5, 1'b0, 1'b0, "dir-round");

    // Empty stream at the fetch cycle
    @(negedge clk);
    start = 1'b1; e_valid = 1'b0;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(done && !tck && cycle_count == 0 && total_time == 0, "R6 empty at fetch", longint'(done), 1);

    // Random variable-period streams
    for (int r = 0; r < 3; r++) begin
      recip = 16'(32'h40 + ($urandom % 32'h100));
      shift_min = 24'($urandom % 20);
      capt_min = 24'($urandom % 40);
      for (int j = 0; j < 20; j++) begin
        e_arr[j] = int'($urandom % 1024);
        t_arr[j] = 1'($urandom % 2);
      end
      run_stream(20, 1'b0, 1'b0, "rand-var");
    end

    // Fixed mode, sync_mode toggled during the run
    recip = 16'h00C0; shift_min = 24'd50; capt_min = 24'd90;
    emax = 16'd0;
    for (int j = 0; j < 16; j++) begin
      e_arr[j] = int'($urandom % 800);
      t_arr[j] = 1'($urandom % 2);
      if (e_arr[j] > int'(emax)) emax = 16'(e_arr[j]);
    end
    run_stream(16, 1'b1, 1'b1, "fixed");

    // Variable mode with sync_mode toggled during the run
    recip = 16'h0100; shift_min = 24'd4; capt_min = 24'd6; emax = 16'd900;
    for (int j = 0; j < 12; j++) begin
      e_arr[j] = int'($urandom % 60);
      t_arr[j] = 1'($urandom % 2);
    end
    run_stream(12, 1'b0, 1'b1, "var-flip");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule